// File: doc/BRIEF.md
# Byte-Checked Register Access Guard

This block sits between a byte-level serial host link and a small bank of configuration registers. The host sends fixed three-byte commands: an opcode, a register address, and a data byte. When checking is on, each of those bytes is followed by an 8-bit check byte, and the guard acts on a byte only after its check byte matches. A read command returns the addressed register as one byte. When checking is on, that byte is followed by a check byte that the guard generates.

A check failure discards the offending byte and the rest of its command, and it latches a sticky error flag. While the flag is set, every register write is refused, except the write that clears the flag. Two control bits decide the side effects of an error. One gives a single-cycle alert pulse when a failure is detected. The other holds a conversion-inhibit output high for as long as the flag stays set, so that free-running conversions stop.

The serial shifter, the converter datapath and any status formatting are outside this block. It sees whole bytes with a valid strobe, a frame-start pulse and a checking-enable level.

Top module: `crcg_top`

## Requirements
- R1: While reset is held, and after it is released, `tx_vld`, `err_flag`, `alert` and `conv_inhibit` are low.
- R2: With `crc_en` high, every returned data byte is followed in the next cycle by a check byte. The check byte is computed with generator 0x07, a register preset to 0xFF, data taken MSB first, and no final inversion.
- R3: With `crc_en` low, commands are three raw bytes, no check byte is expected or returned, and a read gives exactly one byte.
- R4: A command starts with `frm_start`. Its slots are opcode, address and data. Opcode 0x0A writes the data byte to the address and opcode 0x10 reads the address. A read of address 2 or higher returns the last byte written there.
- R5: A check byte that does not match discards its data byte and the remainder of that command, so no register changes.
- R6: A mismatch sets `err_flag`, which is also bit 0 of register 0. The flag is cleared only by a write to address 0 with data bit 0 set. A write of 0 leaves it set.
- R7: While `err_flag` is set, writes to any other address, including the control register at address 1, are ignored.
- R8: If control bit 0 (address 1) is set, `alert` is high for exactly the one cycle after the mismatching check byte is taken. If that bit is clear, `alert` stays low.
- R9: `conv_inhibit` is high exactly while `err_flag` is set and control bit 1 (address 1) is set.
- R10: A read's data byte appears on `tx_vld`/`tx_byte` in the cycle after the command's last byte is taken. `tx_vld` drops after the data byte, or after its check byte when checking is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| crc_en | input | 1 | Enables checking of incoming bytes and appending of outgoing check bytes |
| frm_start | input | 1 | Pulse that starts a new command |
| rx_vld | input | 1 | Incoming byte strobe |
| rx_byte | input | 8 | Incoming byte |
| tx_vld | output | 1 | Outgoing byte strobe |
| tx_byte | output | 8 | Outgoing byte (read data or check byte) |
| err_flag | output | 1 | Sticky check-failure flag |
| alert | output | 1 | One-cycle pulse on a detected failure, when enabled |
| conv_inhibit | output | 1 | Conversion stop request while the flag is set, when enabled |

## Verification
A register write, the setting of the flag, and a clear all take effect at the clock edge that takes the command's final byte, or the failing check byte. The bench drives each byte at a falling edge and samples at the next falling edge, so these results are checked in the half-cycle right after that edge. Read data sits one register further on and is sampled at that same falling edge. Its check byte is sampled one cycle later, and the drop of `tx_vld` one cycle after that. The alert is captured at the failing byte and checked to be low again one cycle later, so any pulse wider than one cycle is caught.

// File: rtl/crcg_pkg.sv
package crcg_pkg;

  localparam logic [7:0] CRC_POLY = 8'h07;
  localparam logic [7:0] CRC_SEED = 8'hFF;
  localparam logic [7:0] OP_WR    = 8'h0A;
  localparam logic [7:0] OP_RD    = 8'h10;

  typedef enum logic [1:0] {
    SLOT_OP   = 2'd0,
    SLOT_ADDR = 2'd1,
    SLOT_DATA = 2'd2
  } slot_e;

  // Single-byte check value: preset, MSB first, no output inversion.
  function automatic logic [7:0] crc8_byte(input logic [7:0] d);
    logic [7:0] c;
    logic       fb;
    c = CRC_SEED;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    end
    return c;
  endfunction

endpackage

// File: rtl/crcg_rx.sv
module crcg_rx
  import crcg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       crc_en,
  input  logic       frm_start,
  input  logic       rx_vld,
  input  logic [7:0] rx_byte,
  output logic       cmd_vld,
  output logic       cmd_wr,
  output logic       cmd_rd,
  output logic [7:0] cmd_addr,
  output logic [7:0] cmd_data,
  output logic       crc_bad
);

  slot_e      slot_q, slot_d;
  logic       phase_q, phase_d;
  logic       dead_q, dead_d;
  logic [7:0] hold_q, hold_d;
  logic [7:0] op_q, op_d;
  logic [7:0] addr_q, addr_d;
  logic       live, take;
  logic [7:0] acc_byte;

  always_comb begin
    live     = rx_vld && !dead_q;
    crc_bad  = live && crc_en && phase_q && (rx_byte != crc8_byte(hold_q));
    take     = live && (!crc_en || phase_q) && !crc_bad;
    acc_byte = crc_en ? hold_q : rx_byte;
    cmd_vld  = take && (slot_q == SLOT_DATA);
    cmd_wr   = (op_q == OP_WR);
    cmd_rd   = (op_q == OP_RD);
    cmd_addr = addr_q;
    cmd_data = acc_byte;
  end

  always_comb begin
    slot_d  = slot_q;
    phase_d = phase_q;
    dead_d  = dead_q;
    hold_d  = hold_q;
    op_d    = op_q;
    addr_d  = addr_q;
    if (frm_start) begin
      slot_d  = SLOT_OP;
      phase_d = 1'b0;
      dead_d  = 1'b0;
    end else if (live) begin
      if (crc_en && !phase_q) begin
        hold_d  = rx_byte;
        phase_d = 1'b1;
      end else begin
        phase_d = 1'b0;
        if (crc_bad) begin
          dead_d = 1'b1;
        end else begin
          case (slot_q)
            SLOT_OP:   begin op_d   = acc_byte; slot_d = SLOT_ADDR; end
            SLOT_ADDR: begin addr_d = acc_byte; slot_d = SLOT_DATA; end
            default:   begin dead_d = 1'b1;     slot_d = SLOT_OP;   end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= SLOT_OP;
      phase_q <= 1'b0;
      dead_q  <= 1'b0;
      hold_q  <= 8'h00;
      op_q    <= 8'h00;
      addr_q  <= 8'h00;
    end else begin
      slot_q  <= slot_d;
      phase_q <= phase_d;
      dead_q  <= dead_d;
      hold_q  <= hold_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
    end
  end

endmodule

// File: rtl/crcg_regs.sv
module crcg_regs #(
  parameter int NREG = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_vld,
  input  logic       cmd_wr,
  input  logic       cmd_rd,
  input  logic [7:0] cmd_addr,
  input  logic [7:0] cmd_data,
  input  logic       crc_bad,
  output logic       rd_req,
  output logic [7:0] rd_data,
  output logic       err_flag,
  output logic       alert,
  output logic       conv_inhibit
);

  localparam int         AW     = $clog2(NREG);
  localparam int         NGP    = NREG - 2;
  localparam logic [7:0] NREG_B = 8'(NREG);

  logic       err_q, err_d;
  logic [1:0] ctrl_q, ctrl_d;
  logic       alert_q, alert_d;
  logic       in_range, wr_ok, clr;
  logic [7:0] view [NREG];

  always_comb begin
    in_range = (cmd_addr < NREG_B);
    wr_ok    = cmd_vld && cmd_wr && in_range && !err_q;
    clr      = cmd_vld && cmd_wr && (cmd_addr == 8'd0) && cmd_data[0];
    err_d    = crc_bad ? 1'b1 : (clr ? 1'b0 : err_q);
    ctrl_d   = (wr_ok && cmd_addr == 8'd1) ? cmd_data[1:0] : ctrl_q;
    alert_d  = crc_bad && ctrl_q[0];
    rd_req   = cmd_vld && cmd_rd && in_range;
    rd_data  = view[cmd_addr[AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      ctrl_q  <= 2'b00;
      alert_q <= 1'b0;
    end else begin
      err_q   <= err_d;
      ctrl_q  <= ctrl_d;
      alert_q <= alert_d;
    end
  end

  assign view[0] = {7'b0, err_q};
  assign view[1] = {6'b0, ctrl_q};

  for (genvar g = 0; g < NGP; g++) begin : g_gp
    logic [7:0] gp_q;
    logic       gp_we;
    assign gp_we = wr_ok && (cmd_addr == 8'(g + 2));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     gp_q <= 8'h00;
      else if (gp_we) gp_q <= cmd_data;
    end
    assign view[g + 2] = gp_q;
  end

  assign err_flag     = err_q;
  assign alert        = alert_q;
  assign conv_inhibit = err_q && ctrl_q[1];

endmodule

// File: rtl/crcg_tx.sv
module crcg_tx
  import crcg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       crc_en,
  input  logic       rd_req,
  input  logic [7:0] rd_data,
  output logic       tx_vld,
  output logic       tx_crc,
  output logic [7:0] tx_byte
);

  logic       vld_q, vld_d;
  logic       crc_q, crc_d;
  logic       pend_q, pend_d;
  logic [7:0] byte_q, byte_d;

  always_comb begin
    vld_d  = 1'b0;
    crc_d  = 1'b0;
    pend_d = 1'b0;
    byte_d = byte_q;
    if (rd_req) begin
      vld_d  = 1'b1;
      byte_d = rd_data;
      pend_d = crc_en;
    end else if (pend_q) begin
      vld_d  = 1'b1;
      crc_d  = 1'b1;
      byte_d = crc8_byte(byte_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      crc_q  <= 1'b0;
      pend_q <= 1'b0;
      byte_q <= 8'h00;
    end else begin
      vld_q  <= vld_d;
      crc_q  <= crc_d;
      pend_q <= pend_d;
      byte_q <= byte_d;
    end
  end

  assign tx_vld  = vld_q;
  assign tx_crc  = crc_q;
  assign tx_byte = byte_q;

endmodule

// File: rtl/crcg_top.sv
module crcg_top #(
  parameter int NREG = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       crc_en,
  input  logic       frm_start,
  input  logic       rx_vld,
  input  logic [7:0] rx_byte,
  output logic       tx_vld,
  output logic [7:0] tx_byte,
  output logic       err_flag,
  output logic       alert,
  output logic       conv_inhibit
);

  logic       rst_m, rst_s;
  logic       cmd_vld, cmd_wr, cmd_rd, crc_bad;
  logic [7:0] cmd_addr, cmd_data;
  logic       rd_req;
  logic [7:0] rd_data;
  logic       tx_crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  crcg_rx u_rx (
    .clk(clk), .rst_n(rst_s), .crc_en(crc_en), .frm_start(frm_start),
    .rx_vld(rx_vld), .rx_byte(rx_byte), .cmd_vld(cmd_vld), .cmd_wr(cmd_wr),
    .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .crc_bad(crc_bad)
  );

  crcg_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_s), .cmd_vld(cmd_vld), .cmd_wr(cmd_wr),
    .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .crc_bad(crc_bad), .rd_req(rd_req), .rd_data(rd_data),
    .err_flag(err_flag), .alert(alert), .conv_inhibit(conv_inhibit)
  );

  crcg_tx u_tx (
    .clk(clk), .rst_n(rst_s), .crc_en(crc_en), .rd_req(rd_req),
    .rd_data(rd_data), .tx_vld(tx_vld), .tx_crc(tx_crc), .tx_byte(tx_byte)
  );

endmodule

// File: rtl/crcg_chk.sv
module crcg_chk
  import crcg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tx_vld,
  input logic       tx_crc,
  input logic [7:0] tx_byte,
  input logic       err_flag,
  input logic       alert,
  input logic       conv_inhibit,
  input logic       crc_bad,
  input logic       cmd_vld,
  input logic       cmd_wr,
  input logic [7:0] cmd_addr,
  input logic       clr_bit
);

  p_crc_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && tx_crc) |->
      ($past(tx_vld) && !$past(tx_crc) && tx_byte == crc8_byte($past(tx_byte))));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(cmd_vld && cmd_wr && cmd_addr == 8'd0 && clr_bit)) |=> err_flag);

  p_set_on_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    crc_bad |=> err_flag);

  p_alert_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alert |-> (err_flag && $past(crc_bad)));

  p_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_inhibit |-> err_flag);

endmodule

bind crcg_top crcg_chk u_chk (
  .clk(clk), .rst_n(rst_s), .tx_vld(tx_vld), .tx_crc(tx_crc),
  .tx_byte(tx_byte), .err_flag(err_flag), .alert(alert),
  .conv_inhibit(conv_inhibit), .crc_bad(crc_bad), .cmd_vld(cmd_vld),
  .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .clr_bit(cmd_data[0])
);

// File: tb/sim_crcg_top.sv
module sim_crcg_top;

  localparam logic [7:0] OPW = 8'h0A;
  localparam logic [7:0] OPR = 8'h10;

  logic       clk = 1'b0;
  logic       rst_n, crc_en, frm_start, rx_vld;
  logic [7:0] rx_byte, tx_byte;
  logic       tx_vld, err_flag, alert, conv_inhibit;
  logic       cap_alert, cap_err, cap_inh;
  int         checks = 0;
  int         errors = 0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  crcg_top #(.NREG(8)) u0 (
    .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .frm_start(frm_start),
    .rx_vld(rx_vld), .rx_byte(rx_byte), .tx_vld(tx_vld), .tx_byte(tx_byte),
    .err_flag(err_flag), .alert(alert), .conv_inhibit(conv_inhibit)
  );

  // Reference check byte: fold the preset into the data, then eight shifts.
  function automatic logic [7:0] ref_crc(input logic [7:0] d);
    logic [7:0] c;
    c = d ^ 8'hFF;
    repeat (8) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    return c;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    rx_byte = b;
    rx_vld  = 1'b1;
    @(negedge clk);
    rx_vld  = 1'b0;
  endtask

  task automatic frame(input logic [7:0] op, input logic [7:0] addr,
                       input logic [7:0] data, input int bad_slot, input int bad_bit);
    logic [7:0] f [3];
    f[0] = op; f[1] = addr; f[2] = data;
    frm_start = 1'b1;
    @(negedge clk);
    frm_start = 1'b0;
    for (int s = 0; s < 3; s++) begin
      put(f[s]);
      if (crc_en) begin
        put(ref_crc(f[s]) ^ ((s == bad_slot) ? 8'(32'd1 << bad_bit) : 8'h00));
        if (s == bad_slot) begin
          cap_alert = alert;
          cap_err   = err_flag;
          cap_inh   = conv_inhibit;
        end
      end
    end
  endtask

  task automatic wr(input logic [7:0] addr, input logic [7:0] data);
    frame(OPW, addr, data, -1, 0);
  endtask

  task automatic rd(input logic [7:0] addr, input logic [7:0] exp, input string tag);
    frame(OPR, addr, 8'h00, -1, 0);
    chk({tag, " R10 data strobe"}, {7'b0, tx_vld}, 8'd1);
    chk(tag, tx_byte, exp);
    @(negedge clk);
    if (crc_en) begin
      chk("R2 check strobe", {7'b0, tx_vld}, 8'd1);
      chk("R2 check byte", tx_byte, ref_crc(exp));
      @(negedge clk);
      chk("R10 strobe drop", {7'b0, tx_vld}, 8'd0);
    end else begin
      chk("R3 no check byte", {7'b0, tx_vld}, 8'd0);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; crc_en = 1'b1; frm_start = 1'b0; rx_vld = 1'b0; rx_byte = 8'h00;
    cap_alert = 1'b0; cap_err = 1'b0; cap_inh = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 tx_vld in reset", {7'b0, tx_vld}, 8'd0);
    chk("R1 err in reset", {7'b0, err_flag}, 8'd0);
    chk("R1 alert in reset", {7'b0, alert}, 8'd0);
    chk("R1 inhibit in reset", {7'b0, conv_inhibit}, 8'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 quiet after reset", {4'b0, tx_vld, err_flag, alert, conv_inhibit}, 8'd0);

    // Checked write/read of every byte value.
    for (int d = 0; d < 256; d++) begin
      wr(8'd2, 8'(d));
      rd(8'd2, 8'(d), "R4 readback checked");
    end

    // Raw mode: no check bytes either way.
    crc_en = 1'b0;
    for (int d = 0; d < 256; d++) begin
      wr(8'd3, 8'(d) ^ 8'h3C);
      rd(8'd3, 8'(d) ^ 8'h3C, "R3 readback raw");
    end
    chk("R3 no error in raw mode", {7'b0, err_flag}, 8'd0);
    crc_en = 1'b1;

    // Corrupt each slot with each single-bit error.
    wr(8'd1, 8'h03);
    wr(8'd2, 8'h5A);
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 8; k++) begin
        frame(OPW, 8'd2, 8'hA5, s, k);
        chk("R6 flag set", {7'b0, cap_err}, 8'd1);
        chk("R8 alert pulse", {7'b0, cap_alert}, 8'd1);
        chk("R9 inhibit with flag", {7'b0, cap_inh}, 8'd1);
        @(negedge clk);
        chk("R8 alert one cycle", {7'b0, alert}, 8'd0);
        rd(8'd2, 8'h5A, "R5 bad data discarded");
        wr(8'd2, 8'h33);
        rd(8'd2, 8'h5A, "R7 write locked");
        wr(8'd1, 8'h00);
        rd(8'd1, 8'h03, "R7 control locked");
        rd(8'd0, 8'h01, "R6 status bit");
        wr(8'd0, 8'h00);
        chk("R6 zero does not clear", {7'b0, err_flag}, 8'd1);
        chk("R9 inhibit held", {7'b0, conv_inhibit}, 8'd1);
        wr(8'd0, 8'h01);
        chk("R6 cleared", {7'b0, err_flag}, 8'd0);
        chk("R9 inhibit released", {7'b0, conv_inhibit}, 8'd0);
      end
    end

    // Side effects disabled.
    wr(8'd1, 8'h00);
    frame(OPW, 8'd4, 8'h77, 2, 0);
    chk("R6 flag set quiet", {7'b0, cap_err}, 8'd1);
    chk("R8 alert off", {7'b0, cap_alert}, 8'd0);
    chk("R9 inhibit off", {7'b0, cap_inh}, 8'd0);
    rd(8'd4, 8'h00, "R5 untouched reg");
    wr(8'd0, 8'h01);
    chk("R6 cleared again", {7'b0, err_flag}, 8'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule